// File: doc/BRIEF.md
# Selectable GPIO Interrupt Channel Array

This block turns a wide bus of GPIO interrupt sources into 32 independent interrupt requests for a parent controller. Each channel picks one line of the 128-line source bus through its own selector byte. It passes that line through a two-flop synchronizer and applies a per-channel sense mode: rising edge, falling edge, level-high or level-low. A pending status bit is latched, or tracked in level modes, and drives a level-high request out of the block.

Software reaches the block through a simple 32-bit word-addressed register port with a write strobe and a combinational read-back. That port holds the packed selector words, two sense-mode words and one status word. Software clears an edge-latched request by writing 0 to its status bit.

Top module: `gpio_irq_array`

## Requirements
- R1: After reset, every selector word, both sense words and the status word read 0, and `irq_o` is 0.
- R2: Channel n's selector is byte (n mod 4) of the word at offset 0x30 + 4*(n/4), at bit shift 8*(n mod 4). Bit 7 of that byte enables the channel and bits 6:0 index the chosen source line. Selector words read back what was written.
- R3: Channel n's sense field is 2 bits wide, at bit 2*(n mod 16) of the word at 0x24 (channels 0-15) or 0x28 (channels 16-31). Sense words read back what was written.
- R4: Sense code 0 (rising) latches the status bit on a 0-to-1 change of the selected source. The bit stays set after the source falls. The request is visible on the third rising clock edge after the source changes.
- R5: Sense code 1 (falling) latches the status bit on a 1-to-0 change of the selected source. A rise alone does not set it.
- R6: With sense code 2 (level-high), the status bit follows the synchronized source while it is high and drops when the source falls.
- R7: With sense code 3 (level-low), the status bit follows the synchronized source while it is low and drops when the source rises.
- R8: The status word sits at offset 0x20, one bit per channel. Writing 0 to a bit clears an edge-latched request. Writing 1 has no effect.
- R9: If an edge event reaches the status bit in the same cycle as a clearing write, the bit stays set.
- R10: A channel whose enable bit is 0 never sets its status bit. Writing a 0 byte disables the channel and reads back as 0 for both the enable bit and the index.
- R11: `irq_o[n]` is high exactly while status bit n is set, and no other request bit moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address (word aligned) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| gpio_src_i | input | 128 | Asynchronous GPIO interrupt source bus |
| irq_o | output | 32 | Level-high request per channel to the parent |

## Verification
The assertions assume two things about the inputs. First, selector and sense fields are changed only while the selected source is quiet, so the synchronizer never mixes two sources into a false edge. Second, register writes are single-cycle strobes with stable address and data. The stimulus respects both. It reprograms a channel only while every source line is low, waits several cycles before and after each configuration write, and clears the status word before each new pattern. Each source change is held for at least five clocks, so every edge crosses the full synchronizer before it is checked.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    SNS_RISE = 2'd0,
    SNS_FALL = 2'd1,
    SNS_HIGH = 2'd2,
    SNS_LOW  = 2'd3
  } sense_e;

  localparam logic [7:0] ADDR_STAT     = 8'h20;
  localparam logic [7:0] ADDR_SNS_BASE = 8'h24;
  localparam logic [7:0] ADDR_SEL_BASE = 8'h30;
  localparam int unsigned CH_PER_SEL   = 4;
  localparam int unsigned CH_PER_SNS   = 16;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned IDX_W  = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [7:0]            addr_i,
  input  logic [31:0]           wdata_i,
  input  logic [NUM_CH-1:0]     status_i,
  output logic [NUM_CH-1:0]     sel_en_o,
  output logic [IDX_W-1:0]      sel_idx_o [NUM_CH],
  output sense_e                sense_o [NUM_CH],
  output logic [NUM_CH-1:0]     clr_o,
  output logic [31:0]           rdata_o
);
  localparam int unsigned SEL_WORDS = NUM_CH / CH_PER_SEL;
  localparam int unsigned SNS_WORDS = NUM_CH / CH_PER_SNS;

  logic [31:0] sel_q [SEL_WORDS];
  logic [31:0] sns_q [SNS_WORDS];

  for (genvar w = 0; w < SEL_WORDS; w++) begin : g_sel
    localparam logic [7:0] WADDR = 8'(ADDR_SEL_BASE + 4 * w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_q[w] <= '0;
      else if (we_i && addr_i == WADDR) sel_q[w] <= wdata_i;
    end

    AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == WADDR) |=> $stable(sel_q[w])) else $error("sel changed without write"); // R2
  end

  for (genvar w = 0; w < SNS_WORDS; w++) begin : g_sns
    localparam logic [7:0] WADDR = 8'(ADDR_SNS_BASE + 4 * w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sns_q[w] <= '0;
      else if (we_i && addr_i == WADDR) sns_q[w] <= wdata_i;
    end

    AST_SNS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == WADDR) |=> $stable(sns_q[w])) else $error("sense changed without write"); // R3
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned SW = c / CH_PER_SEL;
    localparam int unsigned SB = 8 * (c % CH_PER_SEL);
    localparam int unsigned NW = c / CH_PER_SNS;
    localparam int unsigned NB = 2 * (c % CH_PER_SNS);
    assign sel_en_o[c]  = sel_q[SW][SB+7];
    assign sel_idx_o[c] = sel_q[SW][SB +: IDX_W];
    assign sense_o[c]   = sense_e'(sns_q[NW][NB +: 2]);
  end

  // clear on written zeros; ones are ignored
  assign clr_o = (we_i && addr_i == ADDR_STAT) ? ~wdata_i[NUM_CH-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_STAT) rdata_o = 32'(status_i);
    for (int w = 0; w < SEL_WORDS; w++)
      if (addr_i == 8'(ADDR_SEL_BASE + 4 * w)) rdata_o = sel_q[w];
    for (int w = 0; w < SNS_WORDS; w++)
      if (addr_i == 8'(ADDR_SNS_BASE + 4 * w)) rdata_o = sns_q[w];
  end
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128,
  parameter int unsigned IDX_W   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               en_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  sense_e             sense_i,
  input  logic               clr_i,
  output logic               pend_o
);
  logic [2:0] sync_q;   // [0],[1] synchronizer, [2] previous sample
  logic       pend_q;
  logic       hit, lvl, set_en, pend_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], src_i[idx_i]};
  end

  always_comb begin
    lvl = 1'b0;
    unique case (sense_i)
      SNS_RISE: hit = sync_q[1] & ~sync_q[2];
      SNS_FALL: hit = ~sync_q[1] & sync_q[2];
      SNS_HIGH: begin hit = sync_q[1];  lvl = 1'b1; end
      default:  begin hit = ~sync_q[1]; lvl = 1'b1; end
    endcase
    set_en = en_i & hit;
    pend_d = lvl ? set_en : (set_en | (pend_q & ~clr_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_OFF_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !pend_q) |=> !pend_q) else $error("disabled channel set"); // R10
  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sense_i[1] && pend_q && !clr_i) |=> pend_q) else $error("edge pending lost"); // R4
  AST_CLR_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sense_i[1] && clr_i && !en_i) |=> !pend_q) else $error("clear ignored"); // R8
  AST_LVL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SNS_HIGH && en_i) |=> (pend_q == $past(sync_q[1]))) else $error("level track"); // R6
endmodule

// File: rtl/gpio_irq_array.sv
module gpio_irq_array
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_CH  = 32,
  parameter int unsigned NUM_SRC = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_SRC-1:0] gpio_src_i,
  output logic [NUM_CH-1:0]  irq_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic [NUM_CH-1:0] sel_en, clr, pend;
  logic [IDX_W-1:0]  sel_idx [NUM_CH];
  sense_e            sense [NUM_CH];

  gpio_irq_regs #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .status_i(pend), .sel_en_o(sel_en), .sel_idx_o(sel_idx),
    .sense_o(sense), .clr_o(clr), .rdata_o(reg_rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    gpio_irq_chan #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chan (
      .clk_i, .rst_ni, .src_i(gpio_src_i),
      .en_i(sel_en[c]), .idx_i(sel_idx[c]), .sense_i(sense[c]),
      .clr_i(clr[c]), .pend_o(pend[c])
    );
  end

  assign irq_o = pend;

  AST_STAT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_STAT) |-> (reg_rdata_o == 32'(irq_o))) else $error("status/irq mismatch"); // R11
endmodule

// File: tb/gpio_irq_array_tb.sv
module gpio_irq_array_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] src = '0;
  logic [31:0]  irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_array u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .gpio_src_i(src), .irq_o(irq)
  );

  // {chan[4:0], src[6:0], sense[1:0], exp_after_high, exp_after_low}
  localparam logic [15:0] VEC [8] = '{
    {5'd0,  7'd0,   2'd0, 1'b1, 1'b1},
    {5'd5,  7'd127, 2'd1, 1'b0, 1'b1},
    {5'd15, 7'd64,  2'd2, 1'b1, 1'b0},
    {5'd16, 7'd33,  2'd3, 1'b0, 1'b1},
    {5'd21, 7'd100, 2'd0, 1'b1, 1'b1},
    {5'd31, 7'd7,   2'd2, 1'b1, 1'b0},
    {5'd3,  7'd90,  2'd1, 1'b0, 1'b1},
    {5'd27, 7'd127, 2'd3, 1'b0, 1'b1}
  };

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] sel_addr(int ch);
    return 8'(8'h30 + 4 * (ch / 4));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    foreach (VEC[i]) begin end
    for (int a = 8'h20; a <= 8'h3c; a += 4) begin
      if (a == 8'h2c) continue;
      rd(8'(a), d); chk(d, 32'h0, "R1 reset readback");
    end
    chk(irq, 32'h0, "R1 irq after reset");

    // R2 / R3 readback
    wr(8'h34, 32'ha5c3_8101); rd(8'h34, d); chk(d, 32'ha5c3_8101, "R2 selector readback");
    wr(8'h28, 32'h1234_5678); rd(8'h28, d); chk(d, 32'h1234_5678, "R3 sense readback");
    wr(8'h34, 32'h0); wr(8'h28, 32'h0); settle(); wr(8'h20, 32'h0);
    @(negedge clk); chk(irq, 32'h0, "R11 quiet after readback test");

    // table: R4 R5 R6 R7 R11
    for (int i = 0; i < 8; i++) begin
      int ch, sx; logic [1:0] sns; logic e1, e2;
      ch = int'(VEC[i][15:11]); sx = int'(VEC[i][10:4]);
      sns = VEC[i][3:2]; e1 = VEC[i][1]; e2 = VEC[i][0];
      wr(sel_addr(ch), (32'h80 | 32'(sx)) << (8 * (ch % 4)));
      wr(ch < 16 ? 8'h24 : 8'h28, 32'(sns) << (2 * (ch % 16)));
      settle(); wr(8'h20, 32'h0);
      @(negedge clk); src[sx] = 1'b1; settle();
      chk(irq, 32'(e1) << ch, $sformatf("R4-7 vec%0d after rise (R4 R5 R6 R7 R11)", i));
      src[sx] = 1'b0; settle();
      chk(irq, 32'(e2) << ch, $sformatf("R4-7 vec%0d after fall (R4 R5 R6 R7 R11)", i));
      wr(sel_addr(ch), 32'h0); wr(ch < 16 ? 8'h24 : 8'h28, 32'h0);
      settle(); wr(8'h20, 32'h0); @(negedge clk);
      chk(irq, 32'h0, "R8 cleared after vector");
    end

    // R10 disabled channel, then enable, W1 no effect, disable clears byte
    wr(8'h3c, 32'h0000_0014); settle();
    src[20] = 1'b1; settle();
    chk(irq, 32'h0, "R10 disabled channel stays idle");
    rd(8'h3c, d); chk(d, 32'h0000_0014, "R2 index kept while disabled");
    src[20] = 1'b0; settle();
    wr(8'h3c, 32'h0000_0094); settle();
    src[20] = 1'b1; settle();
    chk(irq, 32'h1 << 12, "R4 enabled channel 12 latches");
    wr(8'h20, 32'hffff_ffff); @(negedge clk);
    chk(irq, 32'h1 << 12, "R8 writing one has no effect");
    wr(8'h3c, 32'h0); rd(8'h3c, d);
    chk(d, 32'h0, "R10 disable clears enable and index");
    wr(8'h20, ~(32'h1 << 12)); @(negedge clk);
    chk(irq, 32'h0, "R8 write zero clears");
    src[20] = 1'b0; settle(); src[20] = 1'b1; settle();
    chk(irq, 32'h0, "R10 no set after disable");
    src[20] = 1'b0; settle();

    // R9 event coincides with clear on channel 9, source 10, rising
    wr(8'h38, 32'h0000_8a00); settle();
    src[10] = 1'b1; settle(); src[10] = 1'b0; settle();
    chk(irq, 32'h1 << 9, "R9 pending before race");
    @(negedge clk); src[10] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 8'h20; wdata = 32'h0;
    @(negedge clk); we = 1'b0;
    chk(irq, 32'h1 << 9, "R9 event beats clear");
    wr(8'h20, 32'h0); @(negedge clk);
    chk(irq, 32'h0, "R8 later clear works");
    rd(8'h20, d); chk(d, 32'h0, "R11 status word matches irq");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule